// File: doc/BRIEF.md
# System Tick Countdown Timer

A periodic down-counter meant to pace an operating-system scheduler. Software programs a reload value, picks a count source (every core clock, or one clock in eight), and starts the timer. The counter counts down one step per tick, and on the tick after it reaches zero it takes the reload value again, so the period is reload + 1 ticks. Each time it reaches zero it sets a sticky flag, which software clears by reading the control register. If interrupts are enabled, it also sends a one-cycle exception request that carries exception number 15.

A debug-halt input freezes the count while it is asserted. Any write to the current-value register restarts the sequence from zero. Both count sources are enables in a single clock domain, so the block needs no synchronisers.

Register map, on word addresses from `bus_addr`:

| Address | Register | Access |
|---|---|---|
| 0 | control/status | read/write, except bit 16 (read only) |
| 1 | reload value | read/write |
| 2 | current value | read; any write clears it |
| 3 | spare | reads as zero |

Control/status fields:

| Bit | Field | Meaning |
|---|---|---|
| 0 | run | the counter is running |
| 1 | irq_en | interrupt enable |
| 2 | src_core | 1 counts every core clock, 0 counts one clock in eight |
| 16 | zero flag | read only |

All other bits read as zero.

Top module: `tick_timer_top`

## Requirements
- R1: After reset, the control, reload and current-value registers all read 0, and `tick_irq` is low.
- R2: On each tick the counter decreases by one. On a tick when it already reads zero, it loads the reload value instead.
- R3: Control bits 0, 1 and 2 read back as written. Control bits 3 to 15 and 17 to 31 read 0. Address 3 reads 0.
- R4: When src_core is 0, a tick occurs on every 8th core clock. The divider runs freely from reset: the first divided tick lands on the 8th rising edge after reset release, and every 8th edge after that.
- R5: While `dbg_halt` is high, the current value does not change.
- R6: Control bit 16 becomes 1 when a tick takes the counter from 1 to 0. A read of the control register clears it.
- R7: When irq_en is set, a tick that takes the counter from 1 to 0 raises `tick_irq` for exactly one cycle. In that cycle the current value reads 0 and `tick_exc_num` is 15. At all other times `tick_exc_num` is 0.
- R8: Any write to address 2 sets the count to zero and clears the flag. The count does not reload until the next tick.
- R9: A reload value of 0 gives no further zero events: the flag stays 0 and `tick_irq` stays low.
- R10: If a control read falls in the same cycle as a zero event, that read returns bit 16 = 1 and the flag stays set for the next read.
- R11: The reload register keeps only bits 23:0 of a write. Bits 31:24 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | active-low synchronous reset |
| dbg_halt | input | 1 | freezes the count while high |
| bus_sel | input | 1 | register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | word address of the register |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, combinational from the address |
| tick_irq | output | 1 | one-cycle exception request |
| tick_exc_num | output | 8 | exception number while the request is high, else 0 |

## Verification
A wrong count or a missed reload shows up in the first read of the current value after the faulty tick. An early or late reload also moves every later `tick_irq` pulse by the same number of cycles. A wrong divider phase or a halt that does not stop the count shows up within eight core clocks, as a current value that moves when it should not, or stays when it should move. A flag that is set or cleared wrongly shows up on the next control read. The most delicate case is a control read in the same cycle as a zero event. Reading the control register every few cycles, with several reload values and both count sources, makes reads coincide with zero events.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

   localparam int unsigned BUS_W     = 32;
   localparam int unsigned SEL_W     = 2;
   localparam int unsigned FLAG_POS  = 16;
   localparam int unsigned EXC_W     = 8;
   localparam int unsigned EXC_ID    = 15;

   typedef enum logic [SEL_W-1:0] {
      SEL_CTRL    = 2'd0,
      SEL_RELOAD  = 2'd1,
      SEL_CURRENT = 2'd2,
      SEL_SPARE   = 2'd3
   } reg_sel_e;

   // bit 0 run, bit 1 irq_en, bit 2 src_core
   typedef struct packed {
      logic src_core;
      logic irq_en;
      logic run;
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
   parameter int unsigned DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic div_en
);

   localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam bit POW2 = (DIV > 1) && ((DIV & (DIV - 1)) == 0);

   initial begin
      assert_div_legal_R4 : assert (DIV >= 1);
   end

   generate
      if (DIV == 1) begin : g_pass
         assign div_en = 1'b1;
      end else if (POW2) begin : g_pow2
         logic [PW-1:0] ph_q;
         always_ff @(posedge clk) begin
            if (!rst_n) ph_q <= '0;
            else        ph_q <= ph_q + PW'(1);
         end
         assign div_en = &ph_q;
      end else begin : g_mod
         logic [PW-1:0] ph_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                     ph_q <= '0;
            else if (ph_q == PW'(DIV - 1))  ph_q <= '0;
            else                            ph_q <= ph_q + PW'(1);
         end
         assign div_en = (ph_q == PW'(DIV - 1));
      end

      if (DIV > 1) begin : g_chk
         assert_div_single_R4 : assert property (@(posedge clk) disable iff (!rst_n)
            div_en |=> !div_en);
      end
   endgenerate

endmodule

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
   import tick_timer_pkg::*;
#(
   parameter int unsigned CNT_W = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [SEL_W-1:0]     bus_addr,
   input  logic [BUS_W-1:0]     bus_wdata,
   input  logic [CNT_W-1:0]     cur_cnt,
   input  logic                 flag_view,
   output ctrl_t                ctrl,
   output logic [CNT_W-1:0]     reload,
   output logic                 cur_wr,
   output logic                 ctrl_rd,
   output logic [BUS_W-1:0]     bus_rdata
);

   reg_sel_e sel;
   logic wr_ctrl, wr_reload;
   ctrl_t ctrl_q;
   logic [CNT_W-1:0] reload_q;
   logic unused_wbits;

   assign sel       = reg_sel_e'(bus_addr);
   assign wr_ctrl   = bus_sel &&  bus_wr && (sel == SEL_CTRL);
   assign wr_reload = bus_sel &&  bus_wr && (sel == SEL_RELOAD);
   assign cur_wr    = bus_sel &&  bus_wr && (sel == SEL_CURRENT);
   assign ctrl_rd   = bus_sel && !bus_wr && (sel == SEL_CTRL);
   assign unused_wbits = ^bus_wdata[BUS_W-1:CNT_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         reload_q <= '0;
      end else begin
         if (wr_ctrl)   ctrl_q   <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
         if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (sel)
         SEL_CTRL: begin
            bus_rdata[CTRL_W-1:0] = ctrl_q;
            bus_rdata[FLAG_POS]   = flag_view;
         end
         SEL_RELOAD:  bus_rdata[CNT_W-1:0] = reload_q;
         SEL_CURRENT: bus_rdata[CNT_W-1:0] = cur_cnt;
         default:     bus_rdata = '0;
      endcase
   end

   assign ctrl   = ctrl_q;
   assign reload = reload_q;

   assert_reload_keep_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_reload |=> reload_q == $past(bus_wdata[CNT_W-1:0]));
   assert_ctrl_write_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> ctrl_q == $past(bus_wdata[CTRL_W-1:0]));

endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core
   import tick_timer_pkg::*;
#(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             div_en,
   input  logic             dbg_halt,
   input  ctrl_t            ctrl,
   input  logic [CNT_W-1:0] reload,
   input  logic             cur_wr,
   input  logic             ctrl_rd,
   output logic [CNT_W-1:0] cnt,
   output logic             flag_view,
   output logic             irq_pulse
);

   logic tick, at_zero, reach_zero;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic flag_q, flag_d, irq_q;

   assign tick       = ctrl.run && !dbg_halt && (ctrl.src_core || div_en);
   assign at_zero    = (cnt_q == '0);
   assign reach_zero = tick && !cur_wr && (cnt_q == CNT_W'(1));

   always_comb begin
      cnt_d = cnt_q;
      if (cur_wr)       cnt_d = '0;
      else if (tick)    cnt_d = at_zero ? reload : cnt_q - CNT_W'(1);
   end

   always_comb begin
      flag_d = flag_q;
      if (cur_wr)          flag_d = 1'b0;
      else if (reach_zero) flag_d = 1'b1;
      else if (ctrl_rd)    flag_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         flag_q <= flag_d;
         irq_q  <= reach_zero && ctrl.irq_en;
      end
   end

   assign cnt       = cnt_q;
   assign flag_view = flag_q | reach_zero;
   assign irq_pulse = irq_q;

   assert_count_step_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cur_wr && !at_zero) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
   assert_count_reload_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cur_wr && at_zero) |=> cnt_q == $past(reload));
   assert_halt_hold_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_halt && !cur_wr) |=> $stable(cnt_q));
   assert_flag_set_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      reach_zero |=> flag_q);
   assert_irq_single_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q);
   assert_clear_write_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      cur_wr |=> (cnt_q == '0) && !flag_q);

endmodule

// File: rtl/tick_timer_top.sv
module tick_timer_top
   import tick_timer_pkg::*;
#(
   parameter int unsigned CNT_W    = 24,
   parameter int unsigned DIV      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbg_halt,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [SEL_W-1:0]  bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              tick_irq,
   output logic [EXC_W-1:0]  tick_exc_num
);

   initial begin
      assert_width_legal_R11 : assert (CNT_W >= 2 && CNT_W < BUS_W && CNT_W != FLAG_POS);
   end

   logic div_en, cur_wr, ctrl_rd, flag_view;
   ctrl_t ctrl;
   logic [CNT_W-1:0] reload, cur_cnt;

   tick_prescaler #(.DIV(DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .div_en(div_en));

   tick_timer_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .cur_cnt(cur_cnt), .flag_view(flag_view),
      .ctrl(ctrl), .reload(reload), .cur_wr(cur_wr), .ctrl_rd(ctrl_rd),
      .bus_rdata(bus_rdata));

   tick_timer_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .div_en(div_en), .dbg_halt(dbg_halt),
      .ctrl(ctrl), .reload(reload), .cur_wr(cur_wr), .ctrl_rd(ctrl_rd),
      .cnt(cur_cnt), .flag_view(flag_view), .irq_pulse(tick_irq));

   assign tick_exc_num = tick_irq ? EXC_W'(EXC_ID) : '0;

   assert_irq_at_zero_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      tick_irq |-> (cur_cnt == '0));

endmodule

// File: tb/tick_timer_top_tb_top.sv
module tick_timer_top_tb_top;

   localparam int LIMIT = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dbg_halt = 1'b0;
   logic bus_sel = 1'b0;
   logic bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic tick_irq;
   logic [7:0] tick_exc_num;

   int checks = 0;
   int fails = 0;
   int cyc = 0;

   // reference state, derived from the requirements
   int m_pre;
   logic [23:0] m_cnt, m_reload;
   logic m_flag, m_irq, m_en, m_tie, m_src;

   always #10 clk = ~clk;

   tick_timer_top dut_i (
      .clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tick_irq(tick_irq), .tick_exc_num(tick_exc_num));

   function automatic logic ref_tick();
      return m_en && !dbg_halt && (m_src || m_pre == 7);
   endfunction

   function automatic logic ref_zev();
      return ref_tick() && (m_cnt == 24'd1) && !(bus_sel && bus_wr && bus_addr == 2'd2);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pre = 0; m_cnt = '0; m_reload = '0; m_flag = 0; m_irq = 0;
         m_en = 0; m_tie = 0; m_src = 0;
      end else begin
         logic t, z, rd, wc;
         t  = ref_tick();
         z  = ref_zev();
         rd = bus_sel && !bus_wr && bus_addr == 2'd0;
         wc = bus_sel && bus_wr && bus_addr == 2'd2;
         m_irq = z && m_tie;
         if (wc) m_cnt = '0;
         else if (t) m_cnt = (m_cnt == 0) ? m_reload : m_cnt - 24'd1;
         if (wc) m_flag = 0;
         else if (z) m_flag = 1;
         else if (rd) m_flag = 0;
         if (bus_sel && bus_wr && bus_addr == 2'd0) begin
            m_en = bus_wdata[0]; m_tie = bus_wdata[1]; m_src = bus_wdata[2];
         end
         if (bus_sel && bus_wr && bus_addr == 2'd1) m_reload = bus_wdata[23:0];
         m_pre = (m_pre + 1) % 8;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // R7: request and exception number every cycle
   always @(negedge clk) begin
      if (rst_n) begin
         check("R7 irq", {31'b0, tick_irq}, {31'b0, m_irq});
         check("R7 exc_num", {24'b0, tick_exc_num}, m_irq ? 32'd15 : 32'd0);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > LIMIT) begin
         fails++; checks++;
         $display("FAIL watchdog expired, all requirements unverified");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic do_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic do_read(input logic [1:0] a, input string tag);
      logic [31:0] exp;
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1;
      case (a)
         2'd0: exp = {15'b0, m_flag | ref_zev(), 13'b0, m_src, m_tie, m_en};
         2'd1: exp = {8'b0, m_reload};
         2'd2: exp = {8'b0, m_cnt};
         default: exp = '0;
      endcase
      check(tag, bus_rdata, exp);
      @(negedge clk);
      bus_sel = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      check("R1 irq", {31'b0, tick_irq}, 32'd0);
      do_read(2'd0, "R1 ctrl");
      do_read(2'd1, "R1 reload");
      do_read(2'd2, "R1 current");
      do_read(2'd3, "R3 spare");

      // sweep source, reload and interrupt enable
      for (int src = 0; src < 2; src++)
         for (int rl = 0; rl < 4; rl++)
            for (int tie = 0; tie < 2; tie++) begin
               do_write(2'd0, 32'hFFFE_FFF8);          // R3 upper bits ignored, stopped
               do_read(2'd0, "R3 ctrl readback");
               do_write(2'd1, 32'hA500_0000 | rl);     // R11 upper byte dropped
               do_read(2'd1, "R11 reload width");
               do_write(2'd2, 32'h1234);               // R8 clear
               do_read(2'd2, "R8 current cleared");
               do_write(2'd0, {29'b0, src[0], tie[0], 1'b1});
               for (int k = 0; k < 48; k++) begin
                  if (k % 3 == 0) do_read(2'd0, (rl == 0) ? "R9 flag" : "R6 R10 flag");
                  else do_read(2'd2, src ? "R2 count" : "R4 divided count");
               end
            end

      // R5 debug halt
      do_write(2'd1, 32'd5);
      do_write(2'd0, 32'h7);
      for (int k = 0; k < 8; k++) do_read(2'd2, "R2 before halt");
      dbg_halt = 1;
      for (int k = 0; k < 12; k++) do_read(2'd2, "R5 halted");
      do_read(2'd0, "R5 flag while halted");
      dbg_halt = 0;
      for (int k = 0; k < 12; k++) do_read(2'd2, "R5 resumed");

      // R10 read exactly at a zero event, then again
      do_write(2'd1, 32'd3);
      do_write(2'd2, 32'd0);
      for (int k = 0; k < 16; k++) do_read(2'd0, "R10 back-to-back reads");

      // R4 divided source with halt during prescaler wrap
      do_write(2'd0, 32'h3);
      for (int k = 0; k < 40; k++) begin
         dbg_halt = (k % 5 == 0);
         do_read(2'd2, "R4 R5 divided with halt");
      end
      dbg_halt = 0;

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule